// File: doc/BRIEF.md
# Rounding-Based Approximate Multiplier

This block multiplies two operands of `WIDTH` bits without an array of partial products. Each operand magnitude is rounded to a nearby power of two, and the product is approximated as `Ar*B + Br*A - Ar*Br`. Every one of the three terms is a left shift, so the whole datapath is three barrel shifters, one parallel-prefix adder and one subtraction. The correction term `(Ar-A)*(Br-B)` is dropped. The result can therefore land slightly above or slightly below the exact product.

A parameter picks one of three variants:
- **Unsigned** (no sign logic).
- **Signed with exact negation.** Two's-complement operands are converted to magnitudes, and a negative result is formed as invert plus one.
- **Signed with cheap negation.** Same as above, but the increment is skipped.

A second parameter adds one output register stage, which makes the valid latency 0 or 1 cycle. The block suits error-tolerant datapaths such as image filtering, where energy and delay matter more than the last percent of accuracy.

Top module: `rnd_approx_mult`

## Requirements
- R1: For magnitudes A and B with rounded values Ar and Br, the magnitude of the result is Ar*B + Br*A - Ar*Br. The rounding rule is as follows:
  - Values 0, 1, 2 and 3 round to 0, 1, 2 and 2.
  - For a larger value whose leading one sits at bit k, the result is 2^(k+1) when bit k-1 is set, and 2^k otherwise.
- R2: In mode 0 (unsigned), both operands are unsigned over the full range. An operand of 2^WIDTH-1 rounds up to 2^WIDTH, and the 2*WIDTH-bit product is the unsigned value of R1.
- R3: In modes 1 and 2, the operands are two's complement and the core works on their absolute values. The result is negative exactly when the operand sign bits differ and neither operand is zero. A positive result is output as the R1 magnitude, zero-extended, so bit 2*WIDTH-1 holds the result sign.
- R4: In mode 1, a negative result equals the two's-complement negation of the R1 magnitude.
- R5: In mode 2, a negative result equals the bitwise inversion of the R1 magnitude, which is one less than the exact negation.
- R6: A zero operand yields a product of exactly 0 in every mode.
- R7: When one operand's magnitude is a power of two, the product in modes 0 and 1 equals the exact product.
- R8: In modes 0 and 1, |approx - exact| * 9 <= |exact|. The bound is met with equality at operands of the form 3*2^n.
- R9: With `OUT_REG`=0, `out_valid` equals `in_valid` and the product is combinational. With `OUT_REG`=1, both follow one clock later, and both are 0 while `rst_n` is low.
- R10: With `OUT_REG`=1, the product register loads only in a cycle with `in_valid` high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are valid this cycle |
| op_a | input | WIDTH | First operand (unsigned or two's complement by mode) |
| op_b | input | WIDTH | Second operand |
| out_valid | output | 1 | Product is valid |
| product | output | 2*WIDTH | Approximate product |

## Verification
Every pair of 8-bit operands is applied to three instances at once: unsigned, signed with exact negation (registered), and signed with cheap negation (combinational). The sweep therefore covers each rounding boundary, including values just below and at 3*2^k, together with the max-value round-up. Pairs with a zero operand separate correct sign gating from a stray inverted zero in the cheap-negation variant. Pairs with a power-of-two operand separate the approximation from exact multiplication, and the 3*2^n pairs probe the one-ninth error bound at its limit. Cycles with `in_valid` low, interleaved through the sweep, show whether the registered product holds or reloads.

// File: rtl/rnd_approx_pkg.sv
package rnd_approx_pkg;
   typedef enum int {
      MODE_UNSIGNED      = 0,
      MODE_SIGNED_EXACT  = 1,
      MODE_SIGNED_APPROX = 2
   } mode_e;
endpackage

// File: rtl/rnd_approx_round.sv
// Rounds a magnitude to a power of two; reports its exponent and whether it is nonzero.
module rnd_approx_round #(
   parameter int W  = 8,
   parameter int EW = $clog2(W + 1)
) (
   input  logic [W-1:0]  mag,
   output logic [EW-1:0] expo,
   output logic          nz
);
   logic [EW-1:0] lead;
   logic          below;

   always_comb begin
      lead  = '0;
      below = 1'b0;
      for (int i = 0; i < W; i++) begin
         if (mag[i]) begin
            lead  = EW'(i);
            below = (i >= 2) ? mag[(i >= 1) ? i - 1 : 0] : 1'b0;
         end
      end
      nz   = |mag;
      expo = lead + EW'(below);
   end
endmodule

// File: rtl/rnd_approx_shl.sv
// Logarithmic left barrel shifter.
module rnd_approx_shl #(
   parameter int DW  = 8,
   parameter int OW  = 17,
   parameter int SHW = 4
) (
   input  logic [DW-1:0]  din,
   input  logic [SHW-1:0] amt,
   output logic [OW-1:0]  dout
);
   logic [OW-1:0] stage [0:SHW];

   assign stage[0] = {{(OW-DW){1'b0}}, din};

   for (genvar s = 0; s < SHW; s++) begin : g_stage
      assign stage[s+1] = amt[s] ? (stage[s] << (1 << s)) : stage[s];
   end

   assign dout = stage[SHW];
endmodule

// File: rtl/rnd_approx_ks_add.sv
// Kogge-Stone parallel-prefix adder with carry-in.
module rnd_approx_ks_add #(
   parameter int N = 17
) (
   input  logic [N-1:0] a,
   input  logic [N-1:0] b,
   input  logic         cin,
   output logic [N-1:0] sum
);
   localparam int L = $clog2(N);

   logic [N-1:0] gl [0:L];
   logic [N-1:0] pl [0:L];
   logic [N:0]   carry;

   assign gl[0] = a & b;
   assign pl[0] = a ^ b;

   for (genvar l = 0; l < L; l++) begin : g_lvl
      localparam int S = 1 << l;
      for (genvar i = 0; i < N; i++) begin : g_bit
         if (i >= S) begin : g_comb
            assign gl[l+1][i] = gl[l][i] | (pl[l][i] & gl[l][i-S]);
            assign pl[l+1][i] = pl[l][i] & pl[l][i-S];
         end else begin : g_pass
            assign gl[l+1][i] = gl[l][i];
            assign pl[l+1][i] = pl[l][i];
         end
      end
   end

   assign carry[0] = cin;
   for (genvar i = 0; i < N; i++) begin : g_carry
      assign carry[i+1] = gl[L][i] | (pl[L][i] & cin);
   end

   assign sum = pl[0] ^ carry[N-1:0];
endmodule

// File: rtl/rnd_approx_mult.sv
module rnd_approx_mult #(
   parameter int                    WIDTH   = 8,
   parameter rnd_approx_pkg::mode_e MODE    = rnd_approx_pkg::MODE_SIGNED_EXACT,
   parameter int                    OUT_REG = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [WIDTH-1:0]     op_a,
   input  logic [WIDTH-1:0]     op_b,
   output logic                 out_valid,
   output logic [2*WIDTH-1:0]   product
);
   import rnd_approx_pkg::*;

   localparam int OW = 2 * WIDTH;
   localparam int PW = 2 * WIDTH + 1;
   localparam int EW = $clog2(WIDTH + 1);

   if (WIDTH < 4) begin : g_bad_width
      $error("rnd_approx_mult: WIDTH must be at least 4");
   end
   if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_reg
      $error("rnd_approx_mult: OUT_REG must be 0 or 1");
   end

   // ---- sign detection and magnitudes
   logic [WIDTH-1:0] mag_a, mag_b;
   logic             res_neg;

   if (MODE == MODE_UNSIGNED) begin : g_uns_in
      assign mag_a   = op_a;
      assign mag_b   = op_b;
      assign res_neg = 1'b0;
   end else begin : g_sgn_in
      assign mag_a   = op_a[WIDTH-1] ? (~op_a + 1'b1) : op_a;
      assign mag_b   = op_b[WIDTH-1] ? (~op_b + 1'b1) : op_b;
      assign res_neg = (op_a[WIDTH-1] ^ op_b[WIDTH-1]) & (|op_a) & (|op_b);
   end

   // ---- rounding to powers of two
   logic [EW-1:0] exp_a, exp_b;
   logic          nz_a, nz_b;

   rnd_approx_round #(.W(WIDTH), .EW(EW)) u_round_a (
      .mag (mag_a), .expo(exp_a), .nz(nz_a));
   rnd_approx_round #(.W(WIDTH), .EW(EW)) u_round_b (
      .mag (mag_b), .expo(exp_b), .nz(nz_b));

   // ---- three shift terms
   logic [WIDTH-1:0] src_ab, src_ba;
   logic [1:0]       src_rr;
   logic [EW:0]      exp_sum;
   logic [PW-1:0]    t_ab, t_ba, t_rr;

   assign src_ab  = nz_a ? mag_b : '0;
   assign src_ba  = nz_b ? mag_a : '0;
   assign src_rr  = {1'b0, nz_a & nz_b};
   assign exp_sum = {1'b0, exp_a} + {1'b0, exp_b};

   rnd_approx_shl #(.DW(WIDTH), .OW(PW), .SHW(EW)) u_shl_ab (
      .din(src_ab), .amt(exp_a), .dout(t_ab));
   rnd_approx_shl #(.DW(WIDTH), .OW(PW), .SHW(EW)) u_shl_ba (
      .din(src_ba), .amt(exp_b), .dout(t_ba));
   rnd_approx_shl #(.DW(2), .OW(PW), .SHW(EW+1)) u_shl_rr (
      .din(src_rr), .amt(exp_sum), .dout(t_rr));

   // ---- add cross terms, subtract rounded product
   logic [PW-1:0] cross_sum, diff;

   rnd_approx_ks_add #(.N(PW)) u_add (
      .a(t_ab), .b(t_ba), .cin(1'b0), .sum(cross_sum));
   rnd_approx_ks_add #(.N(PW)) u_sub (
      .a(cross_sum), .b(~t_rr), .cin(1'b1), .sum(diff));

   logic [OW-1:0] mag_res, res;
   assign mag_res = diff[OW-1:0];

   // ---- sign set
   if (MODE == MODE_UNSIGNED) begin : g_uns_out
      assign res = mag_res;
   end else if (MODE == MODE_SIGNED_EXACT) begin : g_exact_out
      assign res = res_neg ? (~mag_res + 1'b1) : mag_res;
   end else begin : g_approx_out
      assign res = res_neg ? ~mag_res : mag_res;
   end

   // ---- optional output register
   if (OUT_REG == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            product   <= '0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) product <= res;
         end
      end
   end else begin : g_comb
      assign out_valid = in_valid;
      assign product   = res;
   end
endmodule

// File: rtl/rnd_approx_mult_chk.sv
module rnd_approx_mult_chk #(
   parameter int W       = 8,
   parameter int MODE    = 1,
   parameter int OUT_REG = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [W-1:0]     op_a,
   input logic [W-1:0]     op_b,
   input logic             out_valid,
   input logic [2*W-1:0]   product
);
   logic         d_valid;
   logic [W-1:0] d_a, d_b;

   if (OUT_REG == 1) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            d_valid <= 1'b0;
            d_a     <= '0;
            d_b     <= '0;
         end else begin
            d_valid <= in_valid;
            if (in_valid) begin
               d_a <= op_a;
               d_b <= op_b;
            end
         end
      end
   end else begin : g_now
      assign d_valid = in_valid;
      assign d_a     = op_a;
      assign d_b     = op_b;
   end

   logic [W-1:0]   m_a;
   logic [2*W-1:0] exact_p;
   always_comb begin
      m_a = (MODE != 0 && d_a[W-1]) ? (~d_a + 1'b1) : d_a;
      if (MODE == 0) exact_p = {{W{1'b0}}, d_a} * {{W{1'b0}}, d_b};
      else           exact_p = {{W{d_a[W-1]}}, d_a} * {{W{d_b[W-1]}}, d_b};
   end

   p_valid_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == d_valid);

   p_zero_operand_r6: assert property (@(posedge clk) disable iff (!rst_n)
      d_valid && (d_a == '0 || d_b == '0) |-> product == '0);

   p_result_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (MODE != 0) && d_valid && d_a != '0 && d_b != '0
      |-> product[2*W-1] == (d_a[W-1] ^ d_b[W-1]));

   p_pow2_exact_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (MODE != 2) && d_valid && $countones(m_a) == 1 |-> product == exact_p);

   if (OUT_REG == 1) begin : g_hold
      p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> $stable(product));
   end
endmodule

bind rnd_approx_mult rnd_approx_mult_chk #(
   .W(WIDTH), .MODE(int'(MODE)), .OUT_REG(OUT_REG)
) u_chk (.*);

// File: tb/test_rnd_approx_mult.sv
`timescale 1ns/1ps
module test_rnd_approx_mult;
   import rnd_approx_pkg::*;

   localparam int W = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           in_valid = 1'b0;
   logic [W-1:0]   op_a = '0, op_b = '0;
   logic           v_main, v_uns, v_apx;
   logic [2*W-1:0] p_main, p_uns, p_apx;

   int n_cmp = 0;
   int n_bad = 0;

   // model state of the registered instance
   logic           m_valid = 1'b0;
   logic [2*W-1:0] m_prod  = '0;

   always #2 clk = ~clk;

   rnd_approx_mult #(.WIDTH(W), .MODE(MODE_SIGNED_EXACT), .OUT_REG(1)) i_rnd_approx_mult (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
      .out_valid(v_main), .product(p_main));

   rnd_approx_mult #(.WIDTH(W), .MODE(MODE_UNSIGNED), .OUT_REG(0)) i_rnd_approx_mult_uns (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
      .out_valid(v_uns), .product(p_uns));

   rnd_approx_mult #(.WIDTH(W), .MODE(MODE_SIGNED_APPROX), .OUT_REG(0)) i_rnd_approx_mult_apx (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
      .out_valid(v_apx), .product(p_apx));

   function automatic longint rnd(longint x);
      int k;
      if (x <= 2) return x;
      if (x == 3) return 2;
      k = 0;
      for (int i = 0; i < 32; i++) if (x[i]) k = i;
      return x[k-1] ? (longint'(1) << (k + 1)) : (longint'(1) << k);
   endfunction

   function automatic longint approx(longint a, longint b);
      return rnd(a) * b + rnd(b) * a - rnd(a) * rnd(b);
   endfunction

   function automatic longint sval(logic [W-1:0] x);
      return x[W-1] ? longint'(x) - (longint'(1) << W) : longint'(x);
   endfunction

   // mode 0/1/2 expected output bits
   function automatic logic [2*W-1:0] expect_p(logic [W-1:0] a, logic [W-1:0] b, int mode);
      longint sa, sb, m, r;
      bit neg;
      if (mode == 0) return (2*W)'(approx(longint'(a), longint'(b)));
      sa = sval(a); sb = sval(b);
      m = approx(sa < 0 ? -sa : sa, sb < 0 ? -sb : sb);
      neg = ((sa < 0) != (sb < 0)) && sa != 0 && sb != 0;
      if (!neg)           r = m;
      else if (mode == 1) r = -m;
      else                r = -m - 1;
      return (2*W)'(r);
   endfunction

   task automatic chk(string req, longint act, longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s a=%0d b=%0d actual=%0h expected=%0h", req, op_a, op_b, act, exp);
      end
   endtask

   task automatic step(logic [W-1:0] a, logic [W-1:0] b, logic v);
      bit zero, p2u, neg_s;
      longint ex, ap, d;
      op_a = a; op_b = b; in_valid = v;
      #1;
      zero = (a == 0) || (b == 0);
      p2u  = ($countones(a) == 1) || ($countones(b) == 1);
      // combinational instances
      chk("R9", v_uns, v);
      chk("R9", v_apx, v);
      if (v) begin
         if (zero)                    chk("R6", p_uns, 0);
         else if (p2u)                chk("R7", p_uns, longint'(a) * longint'(b));
         else if (a[W-1] || b[W-1])   chk("R2", p_uns, expect_p(a, b, 0));
         else                         chk("R1", p_uns, expect_p(a, b, 0));
         if (zero) chk("R6", p_apx, 0);
         else      chk("R5", p_apx, expect_p(a, b, 2));
         // error bound on the unsigned variant
         ex = longint'(a) * longint'(b);
         ap = approx(longint'(a), longint'(b));
         d  = (ap > ex) ? ap - ex : ex - ap;
         chk("R8", (d * 9 <= ex) ? 1 : 0, 1);
      end
      @(posedge clk);
      #1;
      m_valid = v;
      if (v) m_prod = expect_p(a, b, 1);
      neg_s = (a[W-1] != b[W-1]) && !zero;
      chk("R9", v_main, m_valid);
      if (!v)        chk("R10", p_main, m_prod);
      else if (zero) chk("R6", p_main, 0);
      else if (neg_s) chk("R4", p_main, m_prod);
      else           chk("R3", p_main, m_prod);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (2) @(posedge clk);
      #1;
      chk("R9", v_main, 0);
      chk("R9", p_main, 0);
      rst_n = 1'b1;
      // directed corners
      step(8'd96, 8'd96, 1'b1);    // R8 bound at equality, both 3*2^5
      step(8'd3, 8'd3, 1'b1);      // R1 small-value rounding 3 -> 2
      step(8'hFF, 8'hFF, 1'b1);    // R2 round-up to 2^WIDTH; signed -1 * -1
      step(8'h80, 8'h80, 1'b1);    // R3 most negative magnitude
      step(8'h00, 8'hFB, 1'b1);    // R6 zero with negative partner
      step(8'h11, 8'h22, 1'b0);    // R10 idle cycle must not load
      step(8'h10, 8'hC3, 1'b1);    // R7 power of two operand
      step(8'h7F, 8'h81, 1'b1);    // R4 negative result
      // full sweep with idle cycles interleaved
      for (int i = 0; i < 65536; i++) begin
         step(i[7:0], i[15:8], (i % 7) != 3);
      end
      finish_run();
   end
endmodule